// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a segmented logical address (a 16-bit selector plus a 32-bit offset) into a 32-bit linear address. It splits the selector into a table index, a table-choice bit and a requested privilege level. The table-choice bit picks either the global or the local descriptor table. The block reads the addressed descriptor, checks the offset against the descriptor's limit, and returns base plus offset. An offset beyond the limit returns a fault instead.

Both descriptor tables are small register arrays inside the block. They are filled through a single write port. Requests arrive on a valid/ready handshake. Each result is announced by a one-cycle done pulse, and the requested level travels with it unchanged for later stages.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the descriptor index, bit [2] selects the table (0 = global, 1 = local), and bits [1:0] are the requested level.
- R2: A request that passes its checks returns linear = base + offset, truncated to 32 bits; a carry out of bit 31 is dropped and raises no fault.
- R3: An offset strictly greater than the descriptor limit gives fault = 1 with linear = 0; an offset equal to the limit is accepted.
- R4: An index at or above the table depth (default 8) gives fault = 1 with linear = 0, whatever the table contents.
- R5: A request is taken on a cycle with req_valid and req_ready both high. req_ready is low in the following cycle. rsp_done is high for exactly one cycle, starting after the second rising edge counted from the accepting edge.
- R6: rsp_rpl carries selector bits [1:0] of the request that produced the result.
- R7: Reset gives req_ready = 1, rsp_done = 0, rsp_fault = 0, rsp_linear = 0, and clears every descriptor to base 0 and limit 0.
- R8: With wr_en high at a rising edge, wr_base and wr_limit are stored at wr_index of the table that wr_table selects (0 = global, 1 = local), and requests accepted later see the new values. With wr_en low, the tables are left unchanged.
- R9: A write to one table leaves every entry of the other table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_selector | input | 16 | Segment selector |
| req_offset | input | 32 | Offset within the segment |
| wr_en | input | 1 | Descriptor write strobe |
| wr_table | input | 1 | Write target: 0 global, 1 local |
| wr_index | input | 3 | Descriptor slot to write |
| wr_base | input | 32 | Segment base to store |
| wr_limit | input | 32 | Segment limit to store |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Limit or index violation |
| rsp_linear | output | 32 | Linear address, zero on fault |
| rsp_rpl | output | 2 | Requested level of the request |

## Verification
A wrong internal state shows at the ports in the same result that the bad state produces. A wrong table select or a slip in the field split gives a wrong rsp_linear in the done cycle, two edges after the request is accepted. A stuck control state shows as a missing or repeated done pulse, or as req_ready staying high in the cycle after an accept. Stale descriptors after reset show on the first request, as an unexpected address or a missing fault.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W      = 16;
  localparam int OFS_W      = 32;
  localparam int IDX_W      = 13;
  localparam int IDX_LSB    = 3;
  localparam int TI_BIT     = 2;
  localparam int RPL_W      = 2;
  localparam int NUM_TABLES = 2;

  typedef struct packed {
    logic [OFS_W-1:0] base;
    logic [OFS_W-1:0] limit;
  } seg_desc_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } xl_state_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  seg_desc_t       wr_desc,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output seg_desc_t       rd_desc
);
  seg_desc_t mem_q [DEPTH];
  seg_desc_t mem_d [DEPTH];
  seg_desc_t rd_q, rd_d;

  // next-state: array update
  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (wr_en && (int'(wr_addr) < DEPTH)) mem_d[wr_addr] = wr_desc;
  end

  // next-state: synchronous read port
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      if (int'(rd_addr) < DEPTH) rd_d = mem_q[rd_addr];
      else                       rd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      rd_q <= rd_d;
    end
  end

  assign rd_desc = rd_q;
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic result_en
);
  xl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign result_en = (state_q == ST_LOOK);
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc
  import seg_xlate_pkg::*;
(
  input  seg_desc_t         desc,
  input  logic [OFS_W-1:0]  offset,
  input  logic              index_bad,
  output logic              fault,
  output logic [OFS_W-1:0]  linear
);
  logic over_limit;
  logic [OFS_W-1:0] sum;

  always_comb begin
    over_limit = offset > desc.limit;
    sum        = desc.base + offset;   // wraps modulo 2^OFS_W
    fault      = index_bad | over_limit;
    linear     = fault ? '0 : sum;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_selector,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic              wr_en,
  input  logic              wr_table,
  input  logic [AW-1:0]     wr_index,
  input  logic [OFS_W-1:0]  wr_base,
  input  logic [OFS_W-1:0]  wr_limit,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [OFS_W-1:0]  rsp_linear,
  output logic [RPL_W-1:0]  rsp_rpl
);
  logic accept, result_en;

  // selector field split
  logic [IDX_W-1:0] sel_index;
  logic             sel_ti;
  logic [RPL_W-1:0] sel_rpl;
  logic             sel_bad;
  assign sel_index = req_selector[IDX_LSB +: IDX_W];
  assign sel_ti    = req_selector[TI_BIT];
  assign sel_rpl   = req_selector[RPL_W-1:0];
  assign sel_bad   = int'(sel_index) >= DEPTH;

  seg_xlate_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .result_en (result_en)
  );

  // descriptor tables: 0 global, 1 local
  seg_desc_t wr_desc;
  seg_desc_t rd_desc [NUM_TABLES];
  assign wr_desc = '{base: wr_base, limit: wr_limit};

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    seg_desc_table #(.DEPTH(DEPTH), .AW(AW)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_table == t[0])),
      .wr_addr (wr_index),
      .wr_desc (wr_desc),
      .rd_en   (accept),
      .rd_addr (sel_index[AW-1:0]),
      .rd_desc (rd_desc[t])
    );
  end

  // captured request fields
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [RPL_W-1:0] rpl_q, rpl_d;
  logic             ti_q, ti_d;
  logic             bad_q, bad_d;

  always_comb begin
    ofs_d = ofs_q; rpl_d = rpl_q; ti_d = ti_q; bad_d = bad_q;
    if (accept) begin
      ofs_d = req_offset; rpl_d = sel_rpl; ti_d = sel_ti; bad_d = sel_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0; rpl_q <= '0; ti_q <= 1'b0; bad_q <= 1'b0;
    end else begin
      ofs_q <= ofs_d; rpl_q <= rpl_d; ti_q <= ti_d; bad_q <= bad_d;
    end
  end

  logic             calc_fault;
  logic [OFS_W-1:0] calc_linear;

  seg_xlate_calc u_calc (
    .desc      (rd_desc[ti_q]),
    .offset    (ofs_q),
    .index_bad (bad_q),
    .fault     (calc_fault),
    .linear    (calc_linear)
  );

  // result registers
  logic             done_q, done_d;
  logic             fault_q, fault_d;
  logic [OFS_W-1:0] lin_q, lin_d;
  logic [RPL_W-1:0] orpl_q, orpl_d;

  always_comb begin
    done_d  = result_en;
    fault_d = fault_q; lin_d = lin_q; orpl_d = orpl_q;
    if (result_en) begin
      fault_d = calc_fault; lin_d = calc_linear; orpl_d = rpl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; fault_q <= 1'b0; lin_q <= '0; orpl_q <= '0;
    end else begin
      done_q <= done_d; fault_q <= fault_d; lin_q <= lin_d; orpl_q <= orpl_d;
    end
  end

  assign rsp_done   = done_q;
  assign rsp_fault  = fault_q;
  assign rsp_linear = lin_q;
  assign rsp_rpl    = orpl_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_selector,
  input logic        rsp_done,
  input logic        rsp_fault,
  input logic [31:0] rsp_linear,
  input logic [1:0]  rsp_rpl
);
  // R5: done lasts a single cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5: after an accept the block is busy for one cycle
  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_done));

  // R5: the result follows two edges after acceptance
  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 rsp_done);

  // R6: requested level follows the request
  assert_rpl_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 (rsp_rpl == $past(req_selector[1:0], 2)));

  // R3 / R4: a faulting result carries a zero address
  assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |-> (rsp_linear == 32'd0));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_selector (req_selector),
  .rsp_done     (rsp_done),
  .rsp_fault    (rsp_fault),
  .rsp_linear   (rsp_linear),
  .rsp_rpl      (rsp_rpl)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_selector;
  logic [31:0] req_offset;
  logic        wr_en;
  logic        wr_table;
  logic [2:0]  wr_index;
  logic [31:0] wr_base, wr_limit;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_linear;
  logic [1:0]  rsp_rpl;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_selector(req_selector), .req_offset(req_offset),
    .wr_en(wr_en), .wr_table(wr_table), .wr_index(wr_index),
    .wr_base(wr_base), .wr_limit(wr_limit),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_linear(rsp_linear), .rsp_rpl(rsp_rpl)
  );

  // {selector, offset, expected fault, expected linear}
  localparam bit [80:0] VEC [0:10] = '{
    {16'h0008, 32'h0000_0040, 1'b0, 32'h0000_2040},  // R1 R2 global 1
    {16'h000B, 32'h0000_FFFF, 1'b0, 32'h0001_1FFF},  // R3 offset == limit
    {16'h0009, 32'h0001_0000, 1'b1, 32'h0000_0000},  // R3 over limit
    {16'h000C, 32'h0000_0100, 1'b0, 32'h1000_0100},  // R1 R9 local 1
    {16'h000E, 32'h0000_0101, 1'b1, 32'h0000_0000},  // R3 local over
    {16'h0010, 32'h0000_0200, 1'b0, 32'h0000_0100},  // R2 wrap
    {16'h003D, 32'h0000_0800, 1'b0, 32'h0040_0800},  // R1 local 7
    {16'h0038, 32'h0000_0000, 1'b0, 32'h0000_0000},  // R9 global 7 still zero
    {16'h0039, 32'h0000_0001, 1'b1, 32'h0000_0000},  // R9 global 7 limit 0
    {16'h0040, 32'h0000_0000, 1'b1, 32'h0000_0000},  // R4 index 8
    {16'hFFFF, 32'h0000_0000, 1'b1, 32'h0000_0000}   // R4 index max
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_desc(input logic tbl, input logic [2:0] idx,
                         input logic [31:0] b, input logic [31:0] l);
    @(negedge clk);
    wr_en = 1'b1; wr_table = tbl; wr_index = idx; wr_base = b; wr_limit = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_req(input string req, input logic [15:0] sel, input logic [31:0] ofs,
                         input logic exp_f, input logic [31:0] exp_l);
    @(negedge clk);
    chk("R5 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_selector = sel; req_offset = ofs;
    @(negedge clk);                       // accepted at the edge just passed
    req_valid = 1'b0;
    chk("R5 busy", {31'd0, req_ready}, 32'd0);
    chk("R5 no early done", {31'd0, rsp_done}, 32'd0);
    @(negedge clk);                       // second edge: result out
    chk("R5 done", {31'd0, rsp_done}, 32'd1);
    chk(req, {31'd0, rsp_fault}, {31'd0, exp_f});
    chk(req, rsp_linear, exp_l);
    chk("R6 rpl", {30'd0, rsp_rpl}, {30'd0, sel[1:0]});
    @(negedge clk);
    chk("R5 done one cycle", {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_selector = '0; req_offset = '0;
    wr_en = 1'b0; wr_table = 1'b0; wr_index = '0; wr_base = '0; wr_limit = '0;
    repeat (3) @(negedge clk);
    chk("R7 ready", {31'd0, req_ready}, 32'd1);
    chk("R7 done", {31'd0, rsp_done}, 32'd0);
    chk("R7 fault", {31'd0, rsp_fault}, 32'd0);
    chk("R7 linear", rsp_linear, 32'd0);
    rst_n = 1'b1;
    // R7: cleared descriptors
    run_req("R7 zero desc ok", 16'h0008, 32'd0, 1'b0, 32'd0);
    run_req("R7 zero desc fault", 16'h000C, 32'd1, 1'b1, 32'd0);

    wr_desc(1'b0, 3'd1, 32'h0000_2000, 32'h0000_FFFF);
    wr_desc(1'b0, 3'd2, 32'hFFFF_FF00, 32'hFFFF_FFFF);
    wr_desc(1'b1, 3'd1, 32'h1000_0000, 32'h0000_0100);
    wr_desc(1'b1, 3'd7, 32'h0040_0000, 32'h0000_1000);

    for (int i = 0; i < 11; i++)
      run_req("R1-vector", VEC[i][80:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0]);

    // R8: write port held low leaves table unchanged
    @(negedge clk);
    wr_en = 1'b0; wr_table = 1'b0; wr_index = 3'd1; wr_base = 32'hDEAD_0000; wr_limit = 32'd0;
    @(negedge clk);
    run_req("R8 no write", 16'h0008, 32'h40, 1'b0, 32'h0000_2040);
    // R8: overwrite is seen by the next request
    wr_desc(1'b0, 3'd1, 32'h0005_0000, 32'h0000_0010);
    run_req("R8 rewrite", 16'h0008, 32'h10, 1'b0, 32'h0005_0010);
    // R9: local entry 1 unaffected by global write
    run_req("R9 local intact", 16'h000C, 32'h4, 1'b0, 32'h1000_0004);

    // R7: reset in mid-lookup clears outputs and tables
    @(negedge clk);
    req_valid = 1'b1; req_selector = 16'h000C; req_offset = 32'h4;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R7 async ready", {31'd0, req_ready}, 32'd1);
    chk("R7 async done", {31'd0, rsp_done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_req("R7 table cleared", 16'h000C, 32'h4, 1'b1, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule